// File: doc/BRIEF.md
# Four-Lane Deskew Controller

This block takes four parallel receive lanes, each carrying one byte, a control flag and a lane sync-status bit per cycle, and removes the fixed arrival skew between them. Every lane periodically carries an alignment marker: a control byte of value 0x7C with the control flag set. Each lane owns a small elastic FIFO. While deskew is armed, a lane starts storing at its own marker. Once every lane has stored one, all four FIFOs are read together, so the four output lanes present bytes from the same transmit column.

A tracking state machine watches the output columns and drives a channel-aligned status. The status is granted only after four aligned marker columns in a row. It is withdrawn only after a run of bad marker columns. Loss of sync on any lane, or reset, drops the status at once and re-arms the deskew.

Top module: `lane_deskew4`

## Requirements
- R1: The marker is a byte equal to 0x7C with its control flag set. While deskew is armed, each lane begins storing at its own marker. Reading of all lanes starts together once all four have stored one. From then on, `alignValid` is high and every output column holds bytes that sat at the same position on all four lanes. The first valid column is an all-marker column.
- R2: Fixed lane-to-lane arrival skews of up to 6 cycles are absorbed, and the status is acquired for every such skew pattern.
- R3: Each lane FIFO holds 16 entries. If a storing lane would take a 17th entry before all lanes have found a marker, every FIFO is flushed and the search restarts. `alignValid` stays low while any lane lacks a marker.
- R4: After reset, `chanAligned` and `alignValid` are low.
- R5: An aligned column is a valid output column whose four lanes all hold the marker. Starting from loss, `chanAligned` rises in the cycle after the fourth aligned column with no error column between them.
- R6: An error column is a valid output column in which some lanes, but not all, hold the marker, or a FIFO overflow. An error column seen before the status is acquired restarts the count of aligned columns.
- R7: Once acquired, `chanAligned` falls in the cycle after the fourth error column that has no aligned column between it and the first. Each aligned column seen during such a run takes back one error.
- R8: A column without any marker lane, and any cycle with `alignValid` low, leaves the status unchanged.
- R9: If any lane's sync status is low, `chanAligned` and `alignValid` are low in the next cycle and stay low until sync returns and alignment is acquired again.
- R10: Whenever the status is lost, the FIFOs are flushed and deskew is re-armed. An error column seen while not aligned flushes them again, so a changed skew is relearned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxData | input | 32 | Lane bytes, lane i in bits 8i+7..8i |
| rxCtrl | input | 4 | Per-lane control flag |
| rxSyncOk | input | 4 | Per-lane sync status, high when locked |
| alignData | output | 32 | Deskewed lane bytes, same packing as rxData |
| alignCtrl | output | 4 | Deskewed control flags |
| alignValid | output | 1 | Output column holds deskewed data |
| chanAligned | output | 1 | Channel alignment acquired |

## Verification
The bench aims at four areas. The first is timing of the rise on the fourth aligned column: a counter that is off by one would rise a column early or late. The second is a run of three error columns, which must leave the status high, followed by a run of four, which must drop it. The third is an error between aligned columns during acquisition, which a design that fails to restart its count would answer with an early rise. The fourth is a lane that never shows a marker: without the overflow flush, the early lanes would lock to stale markers and put out columns mixed across periods. A mid-run skew change and lane sync loss check that the FIFOs are flushed and relearn. A design that kept stale entries would show mismatched bytes after relock.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  typedef struct packed {
    logic deskewEn;  // lanes may start storing at their marker
    logic flush;     // clear all lane FIFOs this cycle
  } deskewCtl_t;

  typedef enum logic [2:0] {
    ST_LOSS = 3'd0,
    ST_DET1 = 3'd1,
    ST_DET2 = 3'd2,
    ST_DET3 = 3'd3,
    ST_ACQ1 = 3'd4,
    ST_ACQ2 = 3'd5,
    ST_ACQ3 = 3'd6,
    ST_ACQ4 = 3'd7
  } alignState_t;

endpackage

// File: rtl/deskew_lanes.sv
module deskew_lanes
  import lane_deskew_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH = 16,
  parameter logic [BYTE_W-1:0] ALIGN_CODE = 8'h7C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  deskewCtl_t              ctl,
  input  logic [LANES*BYTE_W-1:0] inData,
  input  logic [LANES-1:0]        inCtrl,
  output logic [LANES*BYTE_W-1:0] outData,
  output logic [LANES-1:0]        outCtrl,
  output logic                    outValid,
  output logic                    alignCol,
  output logic                    errCol
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = BYTE_W + 1;

  logic [LANES-1:0] started;
  logic [LANES-1:0] overflow;
  logic [LANES-1:0] outIsAlign;
  logic reading;
  logic flushAll;

  assign reading  = &started;
  assign flushAll = ctl.flush | (|overflow);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] fill;
    logic [ENT_W-1:0] outEnt;
    logic laneStarted, inIsAlign, startNow, doWrite;

    assign inIsAlign = inCtrl[g] && (inData[g*BYTE_W +: BYTE_W] == ALIGN_CODE);
    assign startNow  = ctl.deskewEn && !laneStarted && inIsAlign;
    assign doWrite   = laneStarted || startNow;
    assign overflow[g] = doWrite && !reading && (fill == CNT_W'(DEPTH));
    assign started[g]  = laneStarted;

    always_ff @(posedge clk) begin
      if (doWrite && !flushAll) mem[wrPtr] <= {inCtrl[g], inData[g*BYTE_W +: BYTE_W]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        laneStarted <= 1'b0;
        wrPtr       <= '0;
        rdPtr       <= '0;
        fill        <= '0;
        outEnt      <= '0;
      end else if (flushAll) begin
        laneStarted <= 1'b0;
        wrPtr       <= '0;
        rdPtr       <= '0;
        fill        <= '0;
        outEnt      <= '0;
      end else begin
        if (startNow) laneStarted <= 1'b1;
        if (doWrite) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (reading) rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        fill   <= fill + CNT_W'(doWrite) - CNT_W'(reading);
        outEnt <= reading ? mem[rdPtr] : '0;
      end
    end

    assign outData[g*BYTE_W +: BYTE_W] = outEnt[BYTE_W-1:0];
    assign outCtrl[g]    = outEnt[BYTE_W];
    assign outIsAlign[g] = outEnt[BYTE_W] && (outEnt[BYTE_W-1:0] == ALIGN_CODE);

    // R3: occupancy never passes the FIFO depth
    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= reading && !flushAll;
  end

  assign alignCol = outValid && (&outIsAlign);
  assign errCol   = (outValid && (|outIsAlign) && !(&outIsAlign)) || (|overflow);

  // R1: the first deskewed column is a full marker column
  a_r1_first_col_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> alignCol);

  // R10: a flush empties the output in the next cycle
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.flush |=> !outValid);

endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import lane_deskew_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] laneSyncOk,
  input  logic             alignCol,
  input  logic             errCol,
  output deskewCtl_t       ctl,
  output logic             chanAligned
);
  alignState_t state, nextState;
  logic syncAll;

  assign syncAll = &laneSyncOk;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_LOSS: if (alignCol) nextState = ST_DET1;
      ST_DET1: if (errCol) nextState = ST_LOSS; else if (alignCol) nextState = ST_DET2;
      ST_DET2: if (errCol) nextState = ST_LOSS; else if (alignCol) nextState = ST_DET3;
      ST_DET3: if (errCol) nextState = ST_LOSS; else if (alignCol) nextState = ST_ACQ1;
      ST_ACQ1: if (errCol) nextState = ST_ACQ2;
      ST_ACQ2: if (errCol) nextState = ST_ACQ3; else if (alignCol) nextState = ST_ACQ1;
      ST_ACQ3: if (errCol) nextState = ST_ACQ4; else if (alignCol) nextState = ST_ACQ2;
      ST_ACQ4: if (errCol) nextState = ST_LOSS; else if (alignCol) nextState = ST_ACQ3;
      default: nextState = ST_LOSS;
    endcase
    if (!syncAll) nextState = ST_LOSS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOSS;
    else        state <= nextState;
  end

  always_comb begin
    ctl.deskewEn = (state == ST_LOSS);
    ctl.flush    = !syncAll
                || (state != ST_LOSS && nextState == ST_LOSS)
                || (state == ST_LOSS && errCol);
  end

  assign chanAligned = (state == ST_ACQ1) || (state == ST_ACQ2)
                    || (state == ST_ACQ3) || (state == ST_ACQ4);

  // R9: a lane losing sync removes the status next cycle
  a_r9_sync_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !syncAll |=> !chanAligned);

  // R5: the status only rises on an aligned marker column
  a_r5_rise_on_align: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chanAligned) |-> $past(alignCol));

  // R7: the status only falls on an error column or sync loss
  a_r7_fall_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chanAligned) |-> ($past(errCol) || !$past(syncAll)));

  // R8: marker-free columns leave the tracking state alone
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!alignCol && !errCol && syncAll) |=> $stable(state));

endmodule

// File: rtl/lane_deskew4.sv
module lane_deskew4
  import lane_deskew_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*BYTE_W-1:0] rxData,
  input  logic [LANES-1:0]        rxCtrl,
  input  logic [LANES-1:0]        rxSyncOk,
  output logic [LANES*BYTE_W-1:0] alignData,
  output logic [LANES-1:0]        alignCtrl,
  output logic                    alignValid,
  output logic                    chanAligned
);
  deskewCtl_t ctl;
  logic alignCol, errCol;

  deskew_lanes #(.LANES(LANES), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_lanes (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .inData(rxData), .inCtrl(rxCtrl),
    .outData(alignData), .outCtrl(alignCtrl), .outValid(alignValid),
    .alignCol(alignCol), .errCol(errCol)
  );

  align_fsm #(.LANES(LANES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .laneSyncOk(rxSyncOk),
    .alignCol(alignCol), .errCol(errCol),
    .ctl(ctl), .chanAligned(chanAligned)
  );

endmodule

// File: tb/tb_lane_deskew4.sv
module tb_lane_deskew4;
  localparam int CLK_PERIOD = 10;
  localparam int P = 24;          // marker period in bytes
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] rxData = '0;
  logic [3:0]  rxCtrl = '0;
  logic [3:0]  rxSyncOk = '0;
  logic [31:0] alignData;
  logic [3:0]  alignCtrl;
  logic alignValid, chanAligned;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_deskew4 dut (
    .clk(clk), .rst_n(rst_n), .rxData(rxData), .rxCtrl(rxCtrl), .rxSyncOk(rxSyncOk),
    .alignData(alignData), .alignCtrl(alignCtrl), .alignValid(alignValid),
    .chanAligned(chanAligned)
  );

  int checks = 0, fails = 0, cyc = 0;
  int skew [4];
  int corruptLeft [4];
  bit randCorrupt = 0, dataChk = 0, done = 0;
  logic [3:0] syncDrive = 4'hF;
  int modelSt = 0, acnt = 0, kIdx = 0;
  bit prevIdle = 0, prevAligned = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [8:0] laneSym(int n);
    if (n == 0)  return {1'b1, 8'h7C};
    if (n == 12) return {1'b1, 8'hBC};
    return {1'b0, 8'((n * 29 + 3) & 255)};
  endfunction

  function automatic int nextModel(int st, bit al, bit er, bit syncBad);
    if (syncBad) return 0;
    if (st == 0) return al ? 1 : 0;
    if (st < 4)  return er ? 0 : (al ? st + 1 : st);
    if (er)      return (st == 7) ? 0 : st + 1;
    if (al)      return (st == 4) ? 4 : st - 1;
    return st;
  endfunction

  task automatic step();
    bit anyA, allA, alC, erC;
    @(negedge clk);
    if (rst_n) begin
      chk(chanAligned == (modelSt >= 4), "R5 R6 R7 status track", int'(chanAligned), int'(modelSt >= 4));
      if (prevIdle) chk(chanAligned == prevAligned, "R8 idle column hold", int'(chanAligned), int'(prevAligned));
      if (chanAligned && !prevAligned) chk(acnt == 4, "R5 R6 aligned columns before rise", acnt, 4);
      if (dataChk && alignValid)
        for (int i = 0; i < 4; i++)
          chk({alignCtrl[i], alignData[i*8 +: 8]} == laneSym(kIdx % P), "R1 deskewed column",
              int'({alignCtrl[i], alignData[i*8 +: 8]}), int'(laneSym(kIdx % P)));
    end
    kIdx = alignValid ? kIdx + 1 : 0;
    // drive next inputs
    for (int i = 0; i < 4; i++) begin
      int n;
      logic [8:0] s;
      n = (cyc + 1200 - skew[i]) % P;
      s = laneSym(n);
      if (n == 0 && corruptLeft[i] > 0) begin
        s = {1'b0, 8'h55};
        corruptLeft[i]--;
      end else if (n == 0 && randCorrupt && $urandom_range(5) == 0) begin
        s = {1'b0, 8'h55};
      end
      rxData[i*8 +: 8] = s[7:0];
      rxCtrl[i] = s[8];
    end
    rxSyncOk = syncDrive;
    // reference model from observed outputs
    anyA = 0; allA = 1;
    for (int i = 0; i < 4; i++) begin
      bit a;
      a = alignCtrl[i] && alignData[i*8 +: 8] == 8'h7C;
      anyA |= a;
      allA &= a;
    end
    alC = alignValid && allA;
    erC = alignValid && anyA && !allA;
    if (!rst_n) begin
      modelSt = 0; acnt = 0;
    end else begin
      modelSt = nextModel(modelSt, alC, erC, syncDrive != 4'hF);
      if (syncDrive != 4'hF || erC) acnt = 0;
      else if (alC) acnt++;
    end
    prevAligned = chanAligned;
    prevIdle = rst_n && (syncDrive == 4'hF) && !(alignValid && anyA);
    cyc++;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic waitLock(int maxc, output bit got);
    int used = 0;
    while (!chanAligned && used < maxc) begin
      step();
      used++;
    end
    got = chanAligned;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      skew[i] = 0;
      corruptLeft[i] = 0;
    end
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    bit got;
    int unsigned seedInit;
    seedInit = $urandom(32'd7321);
    skew[0] = 0; skew[1] = 3; skew[2] = 6; skew[3] = 1;
    run(5);
    rst_n = 1'b1;
    step();
    chk(chanAligned == 1'b0, "R4 status after reset", int'(chanAligned), 0);
    chk(alignValid == 1'b0, "R4 valid after reset", int'(alignValid), 0);

    // R1 R2 R5: clean lock with skews 0,3,6,1
    dataChk = 1;
    waitLock(400, got);
    chk(got, "R2 lock with skew 0/3/6/1", int'(got), 1);
    run(100);

    // R7: three errors keep the status
    dataChk = 0;
    corruptLeft[2] = 3;
    run(4 * P);
    chk(chanAligned == 1'b1, "R7 three error columns keep status", int'(chanAligned), 1);
    run(3 * P);
    chk(chanAligned == 1'b1, "R7 back to full alignment", int'(chanAligned), 1);
    // R7: four errors drop it
    corruptLeft[2] = 4;
    run(5 * P);
    chk(chanAligned == 1'b0, "R7 four error columns drop status", int'(chanAligned), 0);
    dataChk = 1;
    waitLock(400, got);
    chk(got, "R10 relock after loss", int'(got), 1);
    run(50);

    // R9: lane sync loss
    syncDrive[1] = 1'b0;
    step();
    step();
    chk(chanAligned == 1'b0, "R9 status after sync loss", int'(chanAligned), 0);
    chk(alignValid == 1'b0, "R9 valid after sync loss", int'(alignValid), 0);
    run(3);
    syncDrive = 4'hF;
    waitLock(400, got);
    chk(got, "R9 recovery after sync return", int'(got), 1);
    run(60);

    // R10: skew change while aligned
    dataChk = 0;
    skew[0] = 2;
    run(2);
    begin
      int used = 0;
      while (chanAligned && used < 400) begin
        step();
        used++;
      end
      chk(chanAligned == 1'b0, "R10 skew change removes status", int'(chanAligned), 0);
    end
    run(3);
    dataChk = 1;
    waitLock(400, got);
    chk(got, "R10 relearn new skew", int'(got), 1);
    run(60);

    // R3: one lane never shows a marker
    syncDrive = 4'h7;
    step();
    syncDrive = 4'hF;
    corruptLeft[3] = 1000;
    for (int i = 0; i < 120; i++) begin
      step();
      chk(alignValid == 1'b0, "R3 no output while a lane lacks a marker", int'(alignValid), 0);
    end
    corruptLeft[3] = 0;
    waitLock(400, got);
    chk(got, "R3 lock after overflow flushes", int'(got), 1);
    run(60);

    // R2: extreme skews
    syncDrive = 4'hE;
    step();
    syncDrive = 4'hF;
    skew[0] = 6; skew[1] = 0; skew[2] = 0; skew[3] = 6;
    run(2);
    waitLock(400, got);
    chk(got, "R2 lock with skew 6/0/0/6", int'(got), 1);
    run(60);

    // constrained random phases
    for (int ph = 0; ph < 10; ph++) begin
      dataChk = 0;
      syncDrive = 4'hF;
      syncDrive[$urandom_range(3)] = 1'b0;
      run(3);
      syncDrive = 4'hF;
      for (int i = 0; i < 4; i++) skew[i] = $urandom_range(6);
      randCorrupt = 1;
      run(500);
      randCorrupt = 0;
      syncDrive = 4'h0;
      step();
      syncDrive = 4'hF;
      dataChk = 1;
      waitLock(400, got);
      chk(got, "R2 lock after random phase", int'(got), 1);
      run(40);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule